// File: doc/BRIEF.md
# Loop Exit Predictor

This block sits next to an ordinary direction predictor. It picks out conditional backward branches that close counted loops. It learns how many times each loop branch is taken before it falls through, and it predicts the fall-through iteration correctly. A predictor that works from outcome history always misses that last iteration.

The loop state is kept in its own small, fully associative table of 16 entries. It is separate from the main history table. Each entry holds:

- the branch address as its tag,
- the learned trip count,
- an iteration counter at resolve time,
- a speculative iteration counter that runs ahead at fetch,
- a 2-bit confidence counter.

A fetch-side lookup returns its answer in the same cycle. Resolved outcomes train the table. A misprediction flush copies the resolve-time counter back into the speculative one, so lookups on the wrong path leave no trace. The surrounding prediction unit uses the direction from this block only when `predHit` is high. In all other cases it keeps the base predictor's guess.

Top module: `loop_exit_predictor`

## Requirements
- R1: After reset the table is empty, so `predHit` and `predTaken` stay 0 for every lookup address.
- R2: The block allocates an entry only for a resolved backward branch (`updateBackward`=1) that has no entry, resolves not-taken, and follows at least one taken resolve of the same address. The learned trip count is the length of that taken run. A branch resolved only as forward never gains an entry. At most one entry matches any address.
- R3: At each not-taken resolve of a tracked branch, the resolve-time counter is compared with the trip count. If they are equal, confidence rises by one and saturates at 3. If they differ, confidence clears to 0 and the trip count is relearned from the counter. So a branch needs four equal-length runs, counting the allocating run, before it is trusted.
- R4: `predHit` is 1 only when `lookupValid` is 1, the lookup address has an entry, and that entry's confidence is 3.
- R5: The answer to a lookup appears combinationally in the same cycle. `predTaken` is 1 while the speculative counter is below the trip count. When the counter has reached the trip count, the prediction is not-taken and the counter clears. Every matching lookup advances the counter, whether or not the entry is confident.
- R6: On `flush`, every speculative counter takes the resolve-time value, including a resolve in the same cycle. A lookup advance in a flush cycle is discarded.
- R7: Allocation uses round-robin order over the 16 entries. The 17th allocation after reset evicts the entry written by the 1st.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Fetch-stage lookup request |
| lookupPc | input | PC_W | Address of the branch being fetched |
| updateValid | input | 1 | Resolve-stage outcome is present |
| updatePc | input | PC_W | Address of the resolved branch |
| updateTaken | input | 1 | Resolved direction, 1 = taken |
| updateBackward | input | 1 | 1 when the branch target is below the branch address |
| flush | input | 1 | Misprediction flush |
| predHit | output | 1 | Confident entry found, so this direction overrides the base predictor |
| predTaken | output | 1 | Predicted direction, valid when predHit is 1 |

## Verification
In one cycle a flush can coincide with a resolve of the same branch and with a wrong-path lookup of it. The block must then load the speculative counter with the value after the resolve and drop the lookup's advance. The bench sets this up directly: it advances a confident loop three steps on the wrong path, then flushes while resolving one taken outcome, and checks the exact iteration at which the next lookups predict the exit. The random phase applies flushes, wrong-path lookups and resolves in the same cycles, and compares every cycle's output with a reference model computed in the bench.

// File: rtl/lp_pkg.sv
package lp_pkg;

  // Strobes from the control to the entry table, one set per cycle.
  typedef struct packed {
    logic specAdv;   // matching lookup advances the speculative counter
    logic train;     // resolved outcome hits an entry
    logic restore;   // flush: speculative counter := resolve-time counter
    logic alloc;     // write a new entry at the round-robin slot
  } lpStrobes_t;

endpackage

// File: rtl/loop_pred_table.sv
module loop_pred_table
  import lp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int ITER_W  = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lpStrobes_t        strb,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [ITER_W-1:0] allocTrip,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [PC_W-1:0]   updatePc,
  input  logic              updateTaken,
  output logic              lookupAny,
  output logic              lookupConf,
  output logic              lookupTaken,
  output logic              updateAny
);

  localparam logic [ITER_W-1:0] ITER_MAX = '1;
  localparam logic [1:0]        CONF_MAX = 2'd3;

  logic [ENTRIES-1:0] lookVec;
  logic [ENTRIES-1:0] updVec;
  logic [ENTRIES-1:0] confVec;
  logic [ENTRIES-1:0] takVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              validQ;
    logic [PC_W-1:0]   tagQ;
    logic [ITER_W-1:0] tripQ, archQ, specQ;
    logic [ITER_W-1:0] tripD, archD, specD;
    logic [1:0]        confQ, confD;
    logic              isUpd, isLook, isAlloc;

    assign lookVec[i] = validQ && (tagQ == lookupPc);
    assign updVec[i]  = validQ && (tagQ == updatePc);
    assign confVec[i] = lookVec[i] && (confQ == CONF_MAX);
    assign takVec[i]  = lookVec[i] && (specQ < tripQ);

    assign isAlloc = strb.alloc && (allocIdx == IDX_W'(i));
    assign isUpd   = strb.train && updVec[i];
    assign isLook  = strb.specAdv && lookVec[i];

    always_comb begin
      archD = archQ;
      tripD = tripQ;
      confD = confQ;
      if (isAlloc) begin
        archD = '0;
        tripD = allocTrip;
        confD = '0;
      end else if (isUpd) begin
        if (updateTaken) begin
          archD = (archQ == ITER_MAX) ? archQ : archQ + 1'b1;
        end else begin
          archD = '0;
          if (archQ == tripQ) begin
            confD = (confQ == CONF_MAX) ? confQ : confQ + 2'd1;
          end else begin
            confD = '0;
            tripD = archQ;
          end
        end
      end
    end

    always_comb begin
      specD = specQ;
      if (isAlloc)           specD = '0;
      else if (strb.restore) specD = archD;
      else if (isLook)       specD = (specQ >= tripQ) ? '0 : specQ + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validQ <= 1'b0;
        tagQ   <= '0;
        tripQ  <= '0;
        archQ  <= '0;
        specQ  <= '0;
        confQ  <= '0;
      end else begin
        if (isAlloc) begin
          validQ <= 1'b1;
          tagQ   <= updatePc;
        end
        tripQ <= tripD;
        archQ <= archD;
        specQ <= specD;
        confQ <= confD;
      end
    end

    // R6: after a flush the speculative counter equals the resolve-time one
    assert_restore_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.restore && !isAlloc) |=> (specQ == archQ));

    // R5: a lookup at or past the trip count wraps the counter to zero
    assert_exit_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (isLook && !strb.restore && !isAlloc && (specQ >= tripQ)) |=> (specQ == '0));

    // R3: an exit at the wrong count drops confidence to zero
    assert_mismatch_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (isUpd && !isAlloc && !updateTaken && (archQ != tripQ)) |=> (confQ == 2'd0));
  end

  assign lookupAny   = |lookVec;
  assign updateAny   = |updVec;
  assign lookupConf  = |confVec;
  assign lookupTaken = |takVec;

  // R2: never two entries for one address
  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lookVec) && $onehot0(updVec));

endmodule

// File: rtl/loop_pred_ctrl.sv
module loop_pred_ctrl
  import lp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int ITER_W  = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic              updateValid,
  input  logic [PC_W-1:0]   updatePc,
  input  logic              updateTaken,
  input  logic              updateBackward,
  input  logic              flush,
  input  logic              lookupAny,
  input  logic              updateAny,
  output lpStrobes_t        strb,
  output logic [IDX_W-1:0]  allocIdx,
  output logic [ITER_W-1:0] allocTrip
);

  localparam logic [ITER_W-1:0] ITER_MAX = '1;
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [PC_W-1:0]   candPcQ;
  logic [ITER_W-1:0] candRunQ;
  logic [IDX_W-1:0]  rrQ;
  logic              newBackward;
  logic              candSame;

  assign newBackward = updateValid && !updateAny && updateBackward;
  assign candSame    = (candRunQ != '0) && (candPcQ == updatePc);

  assign strb.specAdv = lookupValid && lookupAny;
  assign strb.train   = updateValid && updateAny;
  assign strb.restore = flush;
  assign strb.alloc   = newBackward && !updateTaken && candSame;

  assign allocIdx  = rrQ;
  assign allocTrip = candRunQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      candPcQ  <= '0;
      candRunQ <= '0;
      rrQ      <= '0;
    end else begin
      if (newBackward) begin
        if (updateTaken) begin
          if (candSame) begin
            candRunQ <= (candRunQ == ITER_MAX) ? candRunQ : candRunQ + 1'b1;
          end else begin
            candPcQ  <= updatePc;
            candRunQ <= ITER_W'(1);
          end
        end else begin
          candRunQ <= '0;
        end
      end
      if (strb.alloc) begin
        rrQ <= (rrQ == LAST_IDX) ? '0 : rrQ + 1'b1;
      end
    end
  end

  // R7: every allocation moves the victim pointer
  assert_rr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.alloc |=> (rrQ != $past(rrQ)));

  // R2: a taken run that ends in an exit leaves no candidate behind
  assert_cand_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (newBackward && !updateTaken) |=> (candRunQ == '0));

endmodule

// File: rtl/loop_exit_predictor.sv
module loop_exit_predictor
  import lp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int ITER_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lookupValid,
  input  logic [PC_W-1:0] lookupPc,
  input  logic            updateValid,
  input  logic [PC_W-1:0] updatePc,
  input  logic            updateTaken,
  input  logic            updateBackward,
  input  logic            flush,
  output logic            predHit,
  output logic            predTaken
);

  localparam int IDX_W = $clog2(ENTRIES);

  lpStrobes_t        strb;
  logic [IDX_W-1:0]  allocIdx;
  logic [ITER_W-1:0] allocTrip;
  logic              lookupAny, lookupConf, lookupTaken, updateAny;

  loop_pred_ctrl #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ITER_W(ITER_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .updateValid(updateValid),
    .updatePc(updatePc), .updateTaken(updateTaken),
    .updateBackward(updateBackward), .flush(flush),
    .lookupAny(lookupAny), .updateAny(updateAny),
    .strb(strb), .allocIdx(allocIdx), .allocTrip(allocTrip)
  );

  loop_pred_table #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ITER_W(ITER_W)) i_table (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .allocIdx(allocIdx), .allocTrip(allocTrip),
    .lookupPc(lookupPc), .updatePc(updatePc), .updateTaken(updateTaken),
    .lookupAny(lookupAny), .lookupConf(lookupConf),
    .lookupTaken(lookupTaken), .updateAny(updateAny)
  );

  assign predHit   = lookupValid && lookupConf;
  assign predTaken = predHit && lookupTaken;

  // R4: an override needs a lookup and a matching entry
  assert_hit_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    predHit |-> (lookupValid && lookupAny));

endmodule

// File: tb/test_loop_exit_predictor.sv
`timescale 1ns/1ps
module test_loop_exit_predictor;

  localparam int ENT  = 16;
  localparam int IMAX = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookupValid = 1'b0, updateValid = 1'b0, updateTaken = 1'b0;
  logic updateBackward = 1'b0, flush = 1'b0;
  logic [31:0] lookupPc = '0, updatePc = '0;
  logic predHit, predTaken;

  always #2.5 clk = ~clk;

  loop_exit_predictor i_loop_exit_predictor (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .lookupPc(lookupPc),
    .updateValid(updateValid), .updatePc(updatePc),
    .updateTaken(updateTaken), .updateBackward(updateBackward),
    .flush(flush), .predHit(predHit), .predTaken(predTaken)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  bit lastHit, lastTaken;

  // reference model
  bit mValid[ENT];
  logic [31:0] mTag[ENT];
  int mTrip[ENT], mArch[ENT], mSpec[ENT], mConf[ENT];
  logic [31:0] cPc;
  int cRun, rr;

  function automatic int findIdx(logic [31:0] pc);
    for (int i = 0; i < ENT; i++) if (mValid[i] && mTag[i] == pc) return i;
    return -1;
  endfunction

  task automatic checkBit(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < ENT; i++) begin
      mValid[i] = 0; mTag[i] = '0; mTrip[i] = 0; mArch[i] = 0; mSpec[i] = 0; mConf[i] = 0;
    end
    cPc = '0; cRun = 0; rr = 0;
  endtask

  task automatic step(bit lv, logic [31:0] lpc, bit uv, logic [31:0] upc,
                      bit utk, bit ubk, bit fl, string tag);
    int li, ui;
    bit eh, et, alloc;
    @(negedge clk);
    lookupValid = lv; lookupPc = lpc; updateValid = uv; updatePc = upc;
    updateTaken = utk; updateBackward = ubk; flush = fl;
    #1;
    li = findIdx(lpc);
    ui = findIdx(upc);
    eh = lv && li >= 0 && mConf[li] == 3;
    et = eh && mSpec[li] < mTrip[li];
    lastHit = predHit; lastTaken = predTaken;
    checkBit(tag, "predHit", predHit, eh);
    checkBit(tag, "predTaken", predTaken, et);
    alloc = uv && ui < 0 && ubk && !utk && cRun != 0 && cPc == upc;
    for (int i = 0; i < ENT; i++) begin
      int nA, nT, nC, nS;
      bit isUpd, isLook, isAl;
      isUpd = uv && ui == i; isLook = lv && li == i; isAl = alloc && rr == i;
      nA = mArch[i]; nT = mTrip[i]; nC = mConf[i];
      if (isAl) begin nA = 0; nT = cRun; nC = 0; end
      else if (isUpd) begin
        if (utk) nA = (mArch[i] == IMAX) ? IMAX : mArch[i] + 1;
        else begin
          nA = 0;
          if (mArch[i] == mTrip[i]) nC = (mConf[i] == 3) ? 3 : mConf[i] + 1;
          else begin nC = 0; nT = mArch[i]; end
        end
      end
      nS = mSpec[i];
      if (isAl) nS = 0;
      else if (fl) nS = nA;
      else if (isLook) nS = (mSpec[i] >= mTrip[i]) ? 0 : mSpec[i] + 1;
      if (isAl) begin mValid[i] = 1; mTag[i] = upc; end
      mArch[i] = nA; mTrip[i] = nT; mConf[i] = nC; mSpec[i] = nS;
    end
    if (uv && ui < 0 && ubk) begin
      if (utk) begin
        if (cRun != 0 && cPc == upc) cRun = (cRun == IMAX) ? IMAX : cRun + 1;
        else begin cPc = upc; cRun = 1; end
      end else cRun = 0;
    end
    if (alloc) rr = (rr + 1) % ENT;
  endtask

  // one full loop run: trip taken resolves then one not-taken; lookup in lockstep
  task automatic runLoop(logic [31:0] pc, int trip, bit bk, string tag, bit lit);
    for (int k = 0; k <= trip; k++) begin
      step(1, pc, 1, pc, k < trip, bk, 0, tag);
      if (lit) begin
        checkBit(tag, "confident hit in run", lastHit, 1'b1);
        checkBit(tag, "direction by iteration", lastTaken, k < trip);
      end
    end
  endtask

  // lookup only, literal expectation, then a flush to undo the advance
  task automatic probe(logic [31:0] pc, bit eh, bit et, string tag);
    step(1, pc, 0, '0, 0, 0, 0, tag);
    checkBit(tag, "probe hit", lastHit, eh);
    checkBit(tag, "probe taken", lastTaken, et);
    step(0, '0, 0, '0, 0, 0, 1, tag);
  endtask

  localparam logic [31:0] PC_A = 32'h0000_0400;
  localparam logic [31:0] PC_F = 32'h0000_0800;

  initial begin
    logic [31:0] pool[20];
    int ptrip[20], piter[20];
    int cur;
    modelReset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table after reset
    step(0, '0, 0, '0, 0, 0, 0, "R1");
    for (int p = 0; p < 4; p++) probe(32'h100 + 32'(p) * 32'h40, 0, 0, "R1");

    // R2: a forward branch never gains an entry
    for (int r = 0; r < 5; r++) runLoop(PC_F, 4, 0, "R2", 0);
    probe(PC_F, 0, 0, "R2");

    // R3 and R4: three runs are not enough, the fourth makes it confident
    for (int r = 0; r < 3; r++) runLoop(PC_A, 5, 1, "R3", 0);
    probe(PC_A, 0, 0, "R4");
    runLoop(PC_A, 5, 1, "R3", 0);
    probe(PC_A, 1, 1, "R4");

    // R5: confident run predicts five taken then the exit
    runLoop(PC_A, 5, 1, "R5", 1);

    // R6: wrong path advances three, flush together with one taken resolve
    for (int k = 0; k < 3; k++) step(1, PC_A, 0, '0, 0, 0, 0, "R6");
    step(0, '0, 1, PC_A, 1, 1, 1, "R6");
    for (int k = 1; k <= 5; k++) begin
      step(1, PC_A, 1, PC_A, k < 5, 1, 0, "R6");
      checkBit("R6", "direction after restore", lastTaken, k < 5);
    end
    // R6: lookup in the flush cycle is discarded
    step(1, PC_A, 0, '0, 0, 0, 1, "R6");
    step(1, PC_A, 0, '0, 0, 0, 0, "R6");
    checkBit("R6", "counter restored to zero", lastTaken, 1'b1);
    step(0, '0, 0, '0, 0, 0, 1, "R6");

    // R3: a shorter run breaks confidence and relearns three
    runLoop(PC_A, 3, 1, "R3", 0);
    probe(PC_A, 0, 0, "R3");
    for (int r = 0; r < 2; r++) runLoop(PC_A, 3, 1, "R3", 0);
    probe(PC_A, 0, 0, "R3");
    runLoop(PC_A, 3, 1, "R3", 0);
    probe(PC_A, 1, 1, "R3");

    // R7: fifteen more allocations keep A, the sixteenth evicts it
    for (int n = 0; n < 15; n++) runLoop(32'h2000 + 32'(n) * 32'h10, 2, 1, "R7", 0);
    probe(PC_A, 1, 1, "R7");
    runLoop(32'h3000, 2, 1, "R7", 0);
    probe(PC_A, 0, 0, "R7");

    // random phase against the model
    for (int k = 0; k < 20; k++) begin
      pool[k] = 32'h8000 + 32'(k) * 32'h20;
      ptrip[k] = 1 + int'($urandom % 8);
      piter[k] = 0;
    end
    cur = 0;
    for (int c = 0; c < 4000; c++) begin
      bit tk, lv, uv, fl, bk;
      logic [31:0] lpc;
      tk = piter[cur] < ptrip[cur];
      bk = (cur % 5) != 4;
      lv = 1; lpc = pool[cur];
      if ($urandom % 100 < 15) lpc = pool[$urandom % 20];
      uv = ($urandom % 100) < 90;
      fl = ($urandom % 100) < 4;
      step(lv, lpc, uv, pool[cur], tk, bk, fl, "R5");
      if (uv) begin
        if (tk) piter[cur]++;
        else begin
          piter[cur] = 0;
          if ($urandom % 10 == 0) ptrip[cur] = 1 + int'($urandom % 8);
          if ($urandom % 30 == 0) cur = int'($urandom % 20);
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule